// File: doc/BRIEF.md
# Four-Port Serial Management Slave

This block is the management-side front end of a four-port physical-layer device. It takes the management clock and the serial data line, split into an input, an output and an output enable. It decodes read and write frames: start `01`, a two-bit opcode, a 5-bit PHY address, a 5-bit register address, a two-bit turnaround and a 16-bit data field sent MSB first. One base address serves all four ports. The ports answer at four consecutive PHY addresses starting at that base.

The block keeps two registers itself. The first is the status word at register address 01h. Bit 6 of that word is forced high, which tells the station that frames without a preamble are welcome. The second is the base-address register at 19h. At reset it loads its upper three bits from strap pins, and software can rewrite it later. Every other register is served by neighbouring logic through a plain request port.

A read raises `rd_valid` for one cycle with the port index and the register address. The neighbour must return `rd_data` combinationally in that same cycle. A write to any register other than the local pair raises `wr_valid` for one cycle with the port, address and data. Both request paths are valid-only, with no ready and no back-pressure. The serial line cannot stall, so the neighbour must take every beat in the cycle it appears.

Top module: `mdio_mgmt_quad`

## Requirements
- R1: After reset no frame is accepted until the line has been sampled high on 32 consecutive MDC rising edges. A low sample restarts that count. Until then the block never drives the line and raises neither `rd_valid` nor `wr_valid`.
- R2: Once the 32-one run has been seen, frames that start with no preamble at all are decoded.
- R3: Two frames separated by exactly one idle (high) bit are both decoded.
- R4: On a matched read, the line is released during the first turnaround bit and driven 0 during the second. The 16 data bits are then driven MSB first, and the line is released after the last data bit, for 17 driven bit periods in total.
- R5: A write to an external register gives exactly one cycle of `wr_valid`. In that cycle `wr_port`, `wr_addr` and `wr_data` are valid, and the pulse follows the MDC edge that samples the last data bit.
- R6: The ports answer at base+0 through base+3, modulo 32. The port index is the PHY address minus the base. At reset the base is {strap_base, 2'b00}, so strap 3'b100 gives ports at 10h to 13h.
- R7: Writing register 19h through any port sets the base from data bits [4:0], and all four port addresses move together. Reading 19h returns the base in bits [4:0] with zeros above.
- R8: Reading register 01h returns `rd_data` with bit 6 forced to 1. Writes to 01h or 19h are not forwarded on `wr_valid`.
- R9: A frame whose PHY address matches no port is ignored. The line is never driven and neither request strobe rises.
- R10: A start pattern of `00`, or an opcode of `00` or `11`, aborts the frame with no drive and no strobe. After the abort a high bit is needed, and a following valid frame is then decoded.
- R11: On a matched read, `rd_valid` is high for exactly one cycle, during the first turnaround bit. `rd_port` and `rd_addr` are valid in that cycle, and `rd_data` is sampled at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_base | input | 3 | Strap value loaded into base-address bits [4:2] during reset |
| mdio_i | input | 1 | Sampled value of the serial data line |
| mdio_o | output | 1 | Value the block drives onto the line |
| mdio_oe | output | 1 | High while the block drives the line |
| rd_valid | output | 1 | One-cycle read request to neighbouring logic |
| rd_port | output | 2 | Port index of the current frame |
| rd_addr | output | 5 | Register address of the current frame |
| rd_data | input | 16 | Read word supplied by neighbouring logic for `rd_port`/`rd_addr` |
| wr_valid | output | 1 | One-cycle write strobe for external registers |
| wr_port | output | 2 | Port index of the write |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 16 | Write data |

## Verification
The assertions assume the following about the inputs:
- The data line changes only away from the MDC rising edge.
- During a read the station lets go of the line from the first turnaround bit, so the block's drive is never contested.
- The neighbour's `rd_data` is a steady function of `rd_port` and `rd_addr` while `rd_valid` is high.

The stimulus keeps within these rules in three ways:
- It drives every bit on the falling MDC edge.
- It releases its driver to a pull-up for the turnaround and data of every read.
- It models the external registers as a pure function of the request fields.

Every frame the stimulus sends is followed by exactly one idle bit. This exercises the minimum spacing on every frame rather than only in a dedicated case.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [3:0] {
    S_PRE,   // waiting for the first long run of ones after reset
    S_HUNT,  // after a frame or abort: need one high bit
    S_IDLE,  // line idle, a low bit is the first start bit
    S_ST2,   // expecting the second start bit (high)
    S_OP,    // two opcode bits
    S_ADDR,  // PHY address then register address
    S_TA,    // turnaround
    S_DATA,  // sixteen data bits
    S_SKIP   // frame for another device: let it pass
  } mdio_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam int REG_STATUS      = 'h01;
  localparam int REG_PHYBASE     = 'h19;
  localparam int STATUS_NOPRE_BIT = 6;

endpackage

// File: rtl/mdio_port_match.sv
module mdio_port_match #(
  parameter int ADDR_W  = 5,
  parameter int N_PORTS = 4,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              hit,
  output logic [PORT_W-1:0] port_idx
);

  logic [N_PORTS-1:0] eq;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_cmp
    assign eq[gi] = (phy_addr == ADDR_W'(base_addr + ADDR_W'(gi)));
  end

  always_comb begin
    port_idx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (eq[i]) port_idx = PORT_W'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/mdio_local_regs.sv
module mdio_local_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [ADDR_W-1:0]  wr_base,
  input  logic [DATA_W-1:0]  ext_rdata,
  output logic [ADDR_W-1:0]  base_addr,
  output logic [DATA_W-1:0]  rd_word,
  output logic               is_local
);

  localparam int LOW_W = ADDR_W - STRAP_W;

  logic sel_status, sel_base;

  assign sel_status = (reg_addr == ADDR_W'(REG_STATUS));
  assign sel_base   = (reg_addr == ADDR_W'(REG_PHYBASE));
  assign is_local   = sel_status | sel_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  base_addr <= {strap, LOW_W'(0)};
    else if (wr_en && sel_base)  base_addr <= wr_base;
  end

  always_comb begin
    if (sel_base) begin
      rd_word = DATA_W'(base_addr);
    end else begin
      rd_word = ext_rdata;
      if (sel_status) rd_word[STATUS_NOPRE_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int N_PORTS = 4,
  parameter int PRE_LEN = 32,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] cand_phy,
  input  logic              hit,
  input  logic [PORT_W-1:0] hit_port,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              wr_fire,
  output logic [PORT_W-1:0] frame_port,
  output logic [ADDR_W-1:0] frame_reg,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CNT_MAX = (PRE_LEN > DATA_W + 2) ? PRE_LEN : DATA_W + 2;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int HDR_LEN = 2 * ADDR_W;

  mdio_state_e       st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] out_q;
  logic              is_rd_q;
  logic [CNT_W-1:0]  oe_len_q;

  assign cand_phy = sh_q[HDR_LEN-2 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_PRE;
      cnt_q      <= '0;
      sh_q       <= '0;
      out_q      <= '0;
      is_rd_q    <= 1'b0;
      mdio_o     <= 1'b0;
      mdio_oe    <= 1'b0;
      rd_valid   <= 1'b0;
      wr_fire    <= 1'b0;
      frame_port <= '0;
      frame_reg  <= '0;
      wr_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      wr_fire  <= 1'b0;
      case (st_q)
        S_PRE: begin
          if (!mdio_i)                          cnt_q <= '0;
          else if (cnt_q == CNT_W'(PRE_LEN-1)) begin st_q <= S_IDLE; cnt_q <= '0; end
          else                                  cnt_q <= cnt_q + 1'b1;
        end
        S_HUNT: if (mdio_i)  st_q <= S_IDLE;
        S_IDLE: if (!mdio_i) st_q <= S_ST2;
        S_ST2: begin
          cnt_q <= '0;
          st_q  <= mdio_i ? S_OP : S_HUNT;
        end
        S_OP: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == '0) begin
            cnt_q <= 1'b1;
          end else begin
            cnt_q <= '0;
            if ({sh_q[0], mdio_i} == OPC_READ)       begin is_rd_q <= 1'b1; st_q <= S_ADDR; end
            else if ({sh_q[0], mdio_i} == OPC_WRITE) begin is_rd_q <= 1'b0; st_q <= S_ADDR; end
            else                                     st_q <= S_HUNT;
          end
        end
        S_ADDR: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == CNT_W'(HDR_LEN-1)) begin
            cnt_q     <= '0;
            frame_reg <= {sh_q[ADDR_W-2:0], mdio_i};
            if (hit) begin
              st_q       <= S_TA;
              frame_port <= hit_port;
              rd_valid   <= is_rd_q;
            end else begin
              st_q <= S_SKIP;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_TA: begin
          if (cnt_q == '0) begin
            cnt_q <= 1'b1;
            if (is_rd_q) begin
              out_q   <= rd_word;
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end
          end else begin
            cnt_q <= '0;
            st_q  <= S_DATA;
            if (is_rd_q) begin
              mdio_o <= out_q[DATA_W-1];
              out_q  <= {out_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == CNT_W'(DATA_W-1)) begin
            cnt_q   <= '0;
            st_q    <= S_HUNT;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            if (!is_rd_q) begin
              wr_fire <= 1'b1;
              wr_data <= {sh_q[DATA_W-2:0], mdio_i};
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (is_rd_q) begin
              mdio_o <= out_q[DATA_W-1];
              out_q  <= {out_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        S_SKIP: begin
          if (cnt_q == CNT_W'(DATA_W+1)) begin cnt_q <= '0; st_q <= S_HUNT; end
          else                                cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_HUNT;
      endcase
    end
  end

  // checker counter: length of the current drive burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oe_len_q <= '0;
    else if (mdio_oe) oe_len_q <= oe_len_q + 1'b1;
    else              oe_len_q <= '0;
  end

  AST_SILENT_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PRE) |-> !mdio_oe); // R1
  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R4
  AST_DRIVE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> (oe_len_q == CNT_W'(DATA_W+1))); // R4
  AST_DRIVE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(rd_valid)); // R11
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R11
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire); // R5

endmodule

// File: rtl/mdio_mgmt_quad.sv
module mdio_mgmt_quad
  import mdio_mgmt_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int STRAP_W = 3,
  parameter int PRE_LEN = 32,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_base,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_valid,
  output logic [PORT_W-1:0]  rd_port,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wr_valid,
  output logic [PORT_W-1:0]  wr_port,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);

  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] cand_phy;
  logic              hit;
  logic [PORT_W-1:0] hit_port;
  logic [DATA_W-1:0] rd_word;
  logic              wr_fire;
  logic              is_local;
  logic [PORT_W-1:0] frame_port;
  logic [ADDR_W-1:0] frame_reg;
  logic [DATA_W-1:0] frame_wdata;

  mdio_port_match #(.ADDR_W(ADDR_W), .N_PORTS(N_PORTS)) u_match (
    .base_addr (base_addr),
    .phy_addr  (cand_phy),
    .hit       (hit),
    .port_idx  (hit_port)
  );

  mdio_local_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_regs (
    .clk       (mdc),
    .rst_n     (rst_n),
    .strap     (strap_base),
    .wr_en     (wr_fire),
    .reg_addr  (frame_reg),
    .wr_base   (frame_wdata[ADDR_W-1:0]),
    .ext_rdata (rd_data),
    .base_addr (base_addr),
    .rd_word   (rd_word),
    .is_local  (is_local)
  );

  mdio_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PORTS(N_PORTS), .PRE_LEN(PRE_LEN)) u_engine (
    .clk        (mdc),
    .rst_n      (rst_n),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .cand_phy   (cand_phy),
    .hit        (hit),
    .hit_port   (hit_port),
    .rd_word    (rd_word),
    .rd_valid   (rd_valid),
    .wr_fire    (wr_fire),
    .frame_port (frame_port),
    .frame_reg  (frame_reg),
    .wr_data    (frame_wdata)
  );

  assign rd_port  = frame_port;
  assign rd_addr  = frame_reg;
  assign wr_port  = frame_port;
  assign wr_addr  = frame_reg;
  assign wr_data  = frame_wdata;
  assign wr_valid = wr_fire & ~is_local;

endmodule

// File: tb/mdio_mgmt_quad_tb_top.sv
module mdio_mgmt_quad_tb_top;
  localparam int CLK_PERIOD = 20;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'b100;
  logic        m_oe = 1'b1;
  logic        m_val = 1'b0;
  logic        line;
  logic        mdio_o, mdio_oe, rd_valid, wr_valid;
  logic [1:0]  rd_port, wr_port;
  logic [4:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  logic [22:0] wr_last = '0, wr_prev = '0;
  logic [6:0]  rd_last = '0;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  assign line    = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);
  assign rd_data = {4'hA, 2'b00, rd_port, 3'b000, rd_addr};

  mdio_mgmt_quad dut_i (
    .mdc(mdc), .rst_n(rst_n), .strap_base(strap), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_valid(rd_valid), .rd_port(rd_port), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_port(wr_port), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge mdc) begin
    if (wr_valid) begin
      wr_cnt++;
      wr_prev = wr_last;
      wr_last = {wr_port, wr_addr, wr_data};
    end
    if (rd_valid) begin
      rd_cnt++;
      rd_last = {rd_port, rd_addr};
    end
    if (mdio_oe) oe_cnt++;
  end

  function automatic logic [15:0] ext(input logic [1:0] p, input logic [4:0] a);
    return {4'hA, 2'b00, p, 3'b000, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge mdc); m_oe = 1'b1; m_val = b;
    @(posedge mdc);
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    logic [13:0] h;
    h = {2'b01, op, phy, ra};
    for (int i = 13; i >= 0; i--) put_bit(h[i]);
  endtask

  // read frame; ok = turnaround and drive pattern as required, d = bits seen on the line
  task automatic mread(input logic [4:0] phy, input logic [4:0] ra,
                       output logic [15:0] d, output logic ok);
    send_hdr(2'b10, phy, ra);
    ok = 1'b1;
    @(negedge mdc); m_oe = 1'b0;
    if (mdio_oe) ok = 1'b0;
    @(posedge mdc); @(negedge mdc);
    if (!(mdio_oe && !mdio_o)) ok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(posedge mdc); @(negedge mdc);
      d[i] = line;
      if (!mdio_oe) ok = 1'b0;
    end
    @(posedge mdc); @(negedge mdc);
    if (mdio_oe) ok = 1'b0;
    m_oe = 1'b1; m_val = 1'b1;
    @(posedge mdc);
  endtask

  task automatic mwrite(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(2'b01, phy, ra);
    put_bit(1'b1); put_bit(1'b0);
    for (int i = 15; i >= 0; i--) put_bit(d[i]);
    put_bit(1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; m_oe = 1'b1; m_val = 1'b0;
    repeat (3) @(posedge mdc);
    @(negedge mdc); rst_n = 1'b1;
    chk("R1 reset oe", mdio_oe, 0);
    chk("R1 reset strobes", {wr_valid, rd_valid}, 0);
  endtask

  task automatic t_presync;
    logic [15:0] d; logic ok;
    ones(20);
    mwrite(5'h10, 5'h05, 16'h1234);
    mread(5'h10, 5'h02, d, ok);
    chk("R1 no write before sync", wr_cnt, 0);
    chk("R1 no read before sync", rd_cnt, 0);
    chk("R1 no drive before sync", oe_cnt, 0);
    ones(32);
  endtask

  task automatic t_read_basic;
    logic [15:0] d; logic ok;
    mread(5'h12, 5'h07, d, ok);
    chk("R2 no-preamble read data", d, ext(2'd2, 5'h07));
    chk("R4 turnaround and drive span", ok, 1);
    chk("R11 read request fields", rd_last, {2'd2, 5'h07});
    chk("R11 one request", rd_cnt, 1);
  endtask

  task automatic t_ports;
    logic [15:0] d; logic ok;
    for (int p = 0; p < 4; p++) begin
      mread(5'(5'h10 + p), 5'h02, d, ok);
      chk("R6 port mapping", {ok, d}, {1'b1, ext(2'(p), 5'h02)});
    end
    mread(5'h11, 5'h19, d, ok);
    chk("R6 reset base from strap", d, 16'h0010);
  endtask

  task automatic t_write;
    int c0;
    c0 = wr_cnt;
    mwrite(5'h13, 5'h0A, 16'hBEEF);
    chk("R5 write strobe count", wr_cnt - c0, 1);
    chk("R5 write fields", wr_last, {2'd3, 5'h0A, 16'hBEEF});
  endtask

  task automatic t_status;
    logic [15:0] d; logic ok; int c0;
    mread(5'h10, 5'h01, d, ok);
    chk("R8 status bit 6 forced", d, ext(2'd0, 5'h01) | 16'h0040);
    c0 = wr_cnt;
    mwrite(5'h10, 5'h01, 16'h0000);
    chk("R8 status write not forwarded", wr_cnt - c0, 0);
    mread(5'h10, 5'h01, d, ok);
    chk("R8 status unchanged after write", d, ext(2'd0, 5'h01) | 16'h0040);
  endtask

  task automatic t_unmatched;
    logic [15:0] d; logic ok; int w0, r0, o0;
    w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    mread(5'h14, 5'h02, d, ok);
    mread(5'h0F, 5'h02, d, ok);
    mwrite(5'h14, 5'h03, 16'h5555);
    chk("R9 unmatched no drive", oe_cnt - o0, 0);
    chk("R9 unmatched no strobes", {wr_cnt - w0, rd_cnt - r0}, 0);
  endtask

  task automatic t_bad;
    logic [15:0] d; logic ok; int w0, r0, o0;
    w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    put_bit(0); put_bit(0); ones(6);
    put_bit(0); put_bit(1); put_bit(1); put_bit(1); ones(6);
    put_bit(0); put_bit(1); put_bit(0); put_bit(0); ones(6);
    chk("R10 aborted frames silent", {oe_cnt - o0, wr_cnt - w0, rd_cnt - r0}, 0);
    mread(5'h11, 5'h04, d, ok);
    chk("R10 valid frame after abort", {ok, d}, {1'b1, ext(2'd1, 5'h04)});
  endtask

  task automatic t_rebase;
    logic [15:0] d; logic ok; int c0;
    c0 = wr_cnt;
    mwrite(5'h12, 5'h19, 16'h0008);
    chk("R8 base write not forwarded", wr_cnt - c0, 0);
    mread(5'h0B, 5'h03, d, ok);
    chk("R7 moved port 3", {ok, d}, {1'b1, ext(2'd3, 5'h03)});
    mread(5'h08, 5'h19, d, ok);
    chk("R7 base readback", d, 16'h0008);
    mread(5'h10, 5'h03, d, ok);
    chk("R7 old address silent", ok, 0);
    mwrite(5'h08, 5'h19, 16'h0010);
    mread(5'h10, 5'h03, d, ok);
    chk("R7 base restored", {ok, d}, {1'b1, ext(2'd0, 5'h03)});
  endtask

  task automatic t_idle_one;
    logic [15:0] d; logic ok; int c0;
    c0 = wr_cnt;
    mwrite(5'h11, 5'h04, 16'h0F0F);
    mwrite(5'h12, 5'h06, 16'h7001);
    chk("R3 both writes seen", wr_cnt - c0, 2);
    chk("R3 first write", wr_prev, {2'd1, 5'h04, 16'h0F0F});
    chk("R3 second write", wr_last, {2'd2, 5'h06, 16'h7001});
    mread(5'h13, 5'h1F, d, ok);
    chk("R3 read after one idle bit", {ok, d}, {1'b1, ext(2'd3, 5'h1F)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_presync();
    t_read_basic();
    t_ports();
    t_write();
    t_status();
    t_unmatched();
    t_bad();
    t_rebase();
    t_idle_one();
    repeat (4) @(posedge mdc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule